// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block produces the serial clock for an SPI transfer engine from a faster reference clock. A 32-bit configuration word fixes the period of the serial clock through a 6-bit divider field and the length of its high phase through a separate 6-bit count. The duty cycle is therefore set on purpose and is not locked to half the period. The same word also carries a clock-source select bit, which the block stores and drives out for a mux outside the block.

The transfer engine raises `run` to request clocks. While `run` stays high, the generator produces back-to-back periods. With each edge of the serial clock it gives the engine a one-cycle strobe: `sample_stb` at the rising edge and `shift_stb` at the falling edge. When `run` drops, the period in progress runs to its end and the clock then rests low. A configuration write made in the middle of a period does not change the shape of that period. The new values apply from the next period on.

Top module: `serclk_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sck`, `shift_stb`, `sample_stb` and `src_sel` are all 0.
- R2: With divider field n (bits 17:12 of the configuration word, n ≥ 1), each period lasts n+1 reference cycles. `sck` is high for the first h+1 cycles of the period and low for the rest, where h is the high-count field (bits 11:6).
- R3: A divider field of 0 acts as 1, which gives a two-cycle period.
- R4: A high-count field of n or more acts as n-1, so every period has at least one low cycle.
- R5: `sample_stb` is high for exactly one cycle per period: the first cycle of the period, in which `sck` has just gone high.
- R6: `shift_stb` is high for exactly one cycle per period: the first cycle in which `sck` is low. It never coincides with `sample_stb`.
- R7: When `run` is seen high at a clock edge while the generator is idle, the first period starts with that edge.
- R8: If `run` is low at the edge that ends a period, the generator stops after that period, even when `run` fell part way through it.
- R9: A configuration write made during a period takes effect at the start of the next period.
- R10: The low-count field (bits 5:0) has no effect on the waveform. Bit 31 appears on `src_sel` one cycle after the write.
- R11: While idle, `sck` and both strobes stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Clock request from the transfer engine |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| sck | output | 1 | Serial clock, idles low |
| shift_stb | output | 1 | One-cycle strobe at each falling edge of `sck` |
| sample_stb | output | 1 | One-cycle strobe at each rising edge of `sck` |
| src_sel | output | 1 | Stored clock-source select bit |

## Verification
The hardest situations to set up are the ones at a period boundary: a configuration write that arrives while a period is in progress, and a `run` that falls before the period has ended. Both involve state the ports do not show directly. The stimulus writes a new divider one cycle into a burst and expects one full period at the old settings followed by periods at the new ones. In a separate burst it drops `run` several cycles before the final boundary and expects that period to finish in full. A burst with a single-cycle `run` pulse and bursts with clamped field values cover the edge cases at the limits of the counter.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned FUNC_W = 16;

  typedef logic [FUNC_W-1:0] fw_t;

  // Divider value actually used: zero behaves as one.
  function automatic fw_t eff_div(input fw_t raw);
    return (raw == '0) ? fw_t'(1) : raw;
  endfunction

  // High count actually used: kept below the divider so a low phase exists.
  function automatic fw_t eff_hi(input fw_t raw, input fw_t n);
    return (raw >= n) ? n - fw_t'(1) : raw;
  endfunction
endpackage

// File: rtl/serclk_cfg.sv
module serclk_cfg #(
  parameter int unsigned CW      = 6,
  parameter int unsigned RW      = 32,
  parameter int unsigned DIV_LSB = 12,
  parameter int unsigned HI_LSB  = 6,
  parameter int unsigned SRC_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_wdata,
  output logic [CW-1:0] div_raw,
  output logic [CW-1:0] hi_raw,
  output logic          src_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_raw <= CW'(1);
      hi_raw  <= '0;
      src_sel <= 1'b0;
    end else if (cfg_we) begin
      div_raw <= cfg_wdata[DIV_LSB +: CW];
      hi_raw  <= cfg_wdata[HI_LSB +: CW];
      src_sel <= cfg_wdata[SRC_BIT];
    end
  end
endmodule

// File: rtl/serclk_cnt.sv
module serclk_cnt
  import serclk_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] div_raw,
  input  logic [CW-1:0] hi_raw,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] a_div,
  output logic [CW-1:0] a_hi,
  output logic          wrap
);
  logic [CW-1:0] nxt_div;
  logic [CW-1:0] nxt_hi;

  assign nxt_div = CW'(eff_div(FUNC_W'(div_raw)));
  assign nxt_hi  = CW'(eff_hi(FUNC_W'(hi_raw), FUNC_W'(nxt_div)));
  assign wrap    = active && (cnt == a_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      a_div  <= CW'(1);
      a_hi   <= '0;
    end else if (!active || wrap) begin
      cnt <= '0;
      if (run) begin
        active <= 1'b1;
        a_div  <= nxt_div;
        a_hi   <= nxt_hi;
      end else begin
        active <= 1'b0;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/serclk_out.sv
module serclk_out #(
  parameter int unsigned CW = 6
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] a_hi,
  output logic          sck,
  output logic          shift_stb,
  output logic          sample_stb
);
  logic [CW-1:0] fall_at;

  assign fall_at    = a_hi + CW'(1);
  assign sck        = active && (cnt <= a_hi);
  assign sample_stb = active && (cnt == '0);
  assign shift_stb  = active && (cnt == fall_at);
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
  parameter int unsigned CNT_W   = serclk_pkg::CNT_W,
  parameter int unsigned REG_W   = serclk_pkg::REG_W,
  parameter int unsigned DIV_LSB = 12,
  parameter int unsigned HI_LSB  = 6,
  parameter int unsigned SRC_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             sck,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             src_sel
);
  logic [CNT_W-1:0] div_raw;
  logic [CNT_W-1:0] hi_raw;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] a_div;
  logic [CNT_W-1:0] a_hi;
  logic             wrap;

  serclk_cfg #(
    .CW(CNT_W), .RW(REG_W), .DIV_LSB(DIV_LSB), .HI_LSB(HI_LSB), .SRC_BIT(SRC_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .div_raw(div_raw), .hi_raw(hi_raw), .src_sel(src_sel)
  );

  serclk_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .div_raw(div_raw), .hi_raw(hi_raw),
    .active(active), .cnt(cnt), .a_div(a_div), .a_hi(a_hi), .wrap(wrap)
  );

  serclk_out #(.CW(CNT_W)) u_out (
    .active(active), .cnt(cnt), .a_hi(a_hi),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk #(
  parameter int unsigned CW      = 6,
  parameter int unsigned RW      = 32,
  parameter int unsigned SRC_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cfg_we,
  input logic [RW-1:0] cfg_wdata,
  input logic          sck,
  input logic          shift_stb,
  input logic          sample_stb,
  input logic          src_sel,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] a_div,
  input logic          wrap
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= a_div));
  p_rise_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> sample_stb);
  p_fall_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> shift_stb);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !run) |=> !active);
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap) |=> $stable(a_div));
  p_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (src_sel == $past(cfg_wdata[SRC_BIT])));
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sck && !shift_stb && !sample_stb));
endmodule

bind serclk_gen serclk_gen_chk #(.CW(CNT_W), .RW(REG_W), .SRC_BIT(SRC_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb), .src_sel(src_sel),
  .active(active), .cnt(cnt), .a_div(a_div), .wrap(wrap)
);

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sck, shift_stb, sample_stb, src_sel;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  typedef struct { logic [2:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serclk_gen u_serclk_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb), .src_sel(src_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: one comparison after every rising edge, away from the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (mon_on) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " {sck,shift,sample}"}, {29'd0, sck, shift_stb, sample_stb}, {29'd0, e.v});
      end else begin
        check("R11 idle {sck,shift,sample}", {29'd0, sck, shift_stb, sample_stb}, 32'd0);
      end
    end
  end

  function automatic int n_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int h_of(input int d, input int h);
    return (h >= n_of(d)) ? n_of(d) - 1 : h;
  endfunction

  function automatic logic [31:0] word(input bit src, input int d, input int h, input int lo);
    logic [31:0] w;
    w = '0;
    w[31]    = src;
    w[17:12] = 6'(d);
    w[11:6]  = 6'(h);
    w[5:0]   = 6'(lo);
    return w;
  endfunction

  // Expected waveform of one period: high for h+1 cycles, then low.
  task automatic push_period(input int d, input int h, input string tag);
    int n = n_of(d);
    int hh = h_of(d, h);
    for (int k = 0; k <= n; k++) begin
      exp_t e;
      e.v   = {logic'(k <= hh), logic'(k == hh + 1), logic'(k == 0)};
      e.tag = (k == 0) ? {tag, " R7 R5"} : {tag, " R2 R6"};
      exp_q.push_back(e);
    end
  endtask

  task automatic wr_cfg(input bit src, input int d, input int h, input int lo);
    cfg_we = 1'b1;
    cfg_wdata = word(src, d, h, lo);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: first period uses (d1,h1), the rest (d2,h2); d2 is written
  // one cycle into the burst. run drops `early` cycles before the last boundary.
  task automatic burst(input int d1, input int h1, input int d2, input int h2,
                       input int periods, input int early, input int lo, input string tag);
    int k_tot;
    wr_cfg(1'b0, d1, h1, lo);
    push_period(d1, h1, tag);
    for (int p = 1; p < periods; p++) push_period(d2, h2, tag);
    k_tot = (n_of(d1) + 1) + (periods - 1) * (n_of(d2) + 1);
    run = 1'b1;
    for (int j = 0; j < k_tot - early; j++) begin
      @(negedge clk);
      if (j == 0 && periods > 1) begin
        cfg_we = 1'b1;
        cfg_wdata = word(1'b0, d2, h2, lo);
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
    run = 1'b0;
    repeat (early + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sck in reset", {31'd0, sck}, 32'd0);
    check("R1 strobes in reset", {30'd0, shift_stb, sample_stb}, 32'd0);
    check("R1 src_sel in reset", {31'd0, src_sel}, 32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);

    burst(5, 2, 5, 2, 3, 0, 0, "R2 n5h2");
    burst(7, 3, 7, 3, 2, 0, 0, "R2 n7h3");
    burst(1, 0, 1, 0, 4, 0, 0, "R2 n1");
    burst(63, 31, 63, 31, 1, 0, 0, "R2 n63");
    burst(0, 0, 0, 0, 2, 0, 0, "R3 zero div");
    burst(4, 9, 4, 9, 2, 0, 0, "R4 clamp hi");
    burst(2, 2, 2, 2, 1, 0, 0, "R4 hi equals n");
    burst(5, 2, 3, 1, 3, 0, 0, "R9 midperiod write");
    burst(6, 3, 6, 3, 2, 4, 0, "R8 early drop");
    burst(3, 1, 3, 1, 1, 3, 0, "R8 one-cycle run");
    burst(7, 2, 7, 2, 2, 0, 42, "R10 low field");
    burst(7, 2, 7, 2, 1, 0, 63, "R10 low field max");

    wr_cfg(1'b1, 5, 2, 0);
    check("R10 src_sel set", {31'd0, src_sel}, 32'd1);
    repeat (4) @(negedge clk);
    check("R11 idle after cfg write", {31'd0, sck}, 32'd0);
    wr_cfg(1'b0, 5, 2, 0);
    check("R10 src_sel cleared", {31'd0, src_sel}, 32'd0);

    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 32'd0);
    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule